// File: doc/BRIEF.md
# Low-Power State and Wake-Up Controller

This block supervises the power state of a telephony codec chip. An active-low power-down pin puts the chip to sleep. A mode bit chooses between two sleep states: full shutdown, or a listening sleep in which ring detection and the general-purpose interrupt logic stay alive. The block drives power enables for the core and for the serial control interface. It also raises a wake interrupt and keeps a small cause register that tells the host which source woke the chip.

In the listening sleep, a rising edge on the ring input or on a qualified GPIO line can wake the host. A GPIO line qualifies when it is configured as an input and its interrupt is not masked. Such an edge sets a cause bit, asserts the interrupt and powers the serial interface so the host can read the causes. The read clears the causes and drops the interrupt. If the host leaves the chip powered down after that read, the serial interface is switched off again. When every source is masked, the host has to rely on the ring output pin, and the serial interface stays off until the power-down pin is released.

The power-down pin, the ring input and the GPIO inputs each pass through a two-flop synchronizer. The mode bit is captured on entry into sleep.

Top module: `pwc_wake_ctrl`

## Requirements
- R1: After reset the block is in the run state: `core_pwr_en`=1, `sif_pwr_en`=1, `wake_irq`=0, all cause bits 0, `ring_out`=0. Whenever `core_pwr_en` is 1, `sif_pwr_en` is 1.
- R2: `pd_n` passes through two synchronizer flops. A low level of `pd_n` first seen at clock edge E0 drops `core_pwr_en` and `sif_pwr_en` after edge E2.
- R3: If `keep_ring`=0 at sleep entry, the block enters full shutdown. In full shutdown `ring_out`=0 and `sif_pwr_en`=0, and ring and GPIO edges change neither `wake_irq` nor any cause bit.
- R4: If `keep_ring`=1 at sleep entry, the block enters listening sleep. In listening sleep and in run, `ring_out` follows the synchronized ring input. A masked source (`ring_mask`=1, or `gpio_mask[i]`=1) sets no cause bit, raises no interrupt and leaves the serial interface off.
- R5: In listening sleep, an unmasked rising edge on the synchronized ring input sets `cause_ring`, asserts `wake_irq` and sets `sif_pwr_en`, all at the clock edge after the edge is seen.
- R6: A rising edge on GPIO line i wakes the block only when `gpio_dir_in[i]`=1 (configured as input) and `gpio_mask[i]`=0. It then sets `cause_gpio[i]`, asserts `wake_irq` and powers the serial interface.
- R7: A one-cycle `status_rd` pulse clears every cause bit and `wake_irq` at the next edge. If the block is still in listening sleep with `pd_n` low, the same pulse also drops `sif_pwr_en`.
- R8: A wake edge that lands in the same cycle as `status_rd` is kept. Its cause bit is set, `wake_irq` stays 1 and `sif_pwr_en` stays 1.
- R9: A change of `keep_ring` while asleep has no effect on the current sleep state. It is used at the next entry into sleep.
- R10: When the synchronized `pd_n` goes high, the block returns to run and `core_pwr_en` and `sif_pwr_en` go to 1 at the next edge. Cause bits that have not been read are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down request, active low, asynchronous |
| keep_ring | input | 1 | Sleep mode select: 1 keeps ring and GPIO wake alive |
| ring_in | input | 1 | Ring detector output, asynchronous |
| ring_mask | input | 1 | 1 masks the ring wake interrupt |
| gpio_in | input | GPIO_W | GPIO line levels, asynchronous |
| gpio_dir_in | input | GPIO_W | 1 means the line is configured as an input |
| gpio_mask | input | GPIO_W | 1 masks the line's wake interrupt |
| status_rd | input | 1 | Strobe for a read of the cause register |
| core_pwr_en | output | 1 | Core power enable |
| sif_pwr_en | output | 1 | Serial control interface power enable |
| wake_irq | output | 1 | Wake interrupt, high while any cause bit is set |
| ring_out | output | 1 | Ring indication pin |
| cause_ring | output | 1 | Cause bit: the ring woke the chip |
| cause_gpio | output | GPIO_W | Cause bits: GPIO line i woke the chip |

## Verification
The assertions check, on every cycle, the relations between state and outputs. The core is never on without the serial interface, and full shutdown keeps everything silent. A rising interrupt always comes with the serial interface powered. A read clears the interrupt unless a new edge arrives with it. The sleep state is held while the pin stays low, and run follows a released pin. The bench alone can show the effects that need timing and history: the two-flop latency of each input, and that only rising edges wake. It also covers GPIO qualification by direction and mask, mode capture at entry, and a read colliding with a fresh event. For these it compares every output against a behavioural model on each clock.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_OFF    = 2'd1,
    PS_LISTEN = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/pwc_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
module pwc_sync #(
  parameter int unsigned          WIDTH   = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pwc_power_fsm.sv
// Sleep/run state machine; the mode is captured on sleep entry only.
module pwc_power_fsm
  import pwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_n_s,
  input  logic       keep_ring,
  output pwr_state_t state_q
);
  pwr_state_t state_nxt;

  always_comb begin
    state_nxt = state_q;
    if (pd_n_s) begin
      state_nxt = PS_RUN;
    end else if (state_q == PS_RUN) begin
      state_nxt = keep_ring ? PS_LISTEN : PS_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_RUN;
    else        state_q <= state_nxt;
  end
endmodule

// File: rtl/pwc_wake_detect.sv
// Edge qualification, cause register and serial-interface wake flag.
module pwc_wake_detect #(
  parameter int unsigned GPIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_s,
  input  logic [GPIO_W-1:0] gpio_s,
  input  logic              ring_mask,
  input  logic [GPIO_W-1:0] gpio_dir_in,
  input  logic [GPIO_W-1:0] gpio_mask,
  input  logic              armed,
  input  logic              in_run,
  input  logic              status_rd,
  output logic              cause_ring,
  output logic [GPIO_W-1:0] cause_gpio,
  output logic              awake,
  output logic              any_hit
);
  logic              ring_d;
  logic [GPIO_W-1:0] gpio_d;
  logic              ring_hit;
  logic [GPIO_W-1:0] gpio_hit;
  logic              cause_en;
  logic              cause_ring_nxt;
  logic [GPIO_W-1:0] cause_gpio_nxt;
  logic              awake_en;
  logic              awake_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_d <= 1'b0;
      gpio_d <= '0;
    end else begin
      ring_d <= ring_s;
      gpio_d <= gpio_s;
    end
  end

  always_comb begin
    ring_hit       = armed & ring_s & ~ring_d & ~ring_mask;
    gpio_hit       = {GPIO_W{armed}} & gpio_s & ~gpio_d & gpio_dir_in & ~gpio_mask;
    any_hit        = ring_hit | (|gpio_hit);
    cause_en       = status_rd | any_hit;
    cause_ring_nxt = (cause_ring & ~status_rd) | ring_hit;
    cause_gpio_nxt = (cause_gpio & ~{GPIO_W{status_rd}}) | gpio_hit;
    awake_en       = in_run | status_rd | any_hit;
    awake_nxt      = in_run ? 1'b0 : ((awake & ~status_rd) | any_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_ring <= 1'b0;
      cause_gpio <= '0;
    end else if (cause_en) begin
      cause_ring <= cause_ring_nxt;
      cause_gpio <= cause_gpio_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        awake <= 1'b0;
    else if (awake_en) awake <= awake_nxt;
  end
endmodule

// File: rtl/pwc_wake_ctrl.sv
module pwc_wake_ctrl
  import pwc_pkg::*;
#(
  parameter int unsigned GPIO_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              keep_ring,
  input  logic              ring_in,
  input  logic              ring_mask,
  input  logic [GPIO_W-1:0] gpio_in,
  input  logic [GPIO_W-1:0] gpio_dir_in,
  input  logic [GPIO_W-1:0] gpio_mask,
  input  logic              status_rd,
  output logic              core_pwr_en,
  output logic              sif_pwr_en,
  output logic              wake_irq,
  output logic              ring_out,
  output logic              cause_ring,
  output logic [GPIO_W-1:0] cause_gpio
);
  logic              pd_s;
  logic              ring_s;
  logic [GPIO_W-1:0] gpio_s;
  pwr_state_t        state_q;
  logic              awake;
  logic              any_hit;

  pwc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .rst_n(rst_n), .d(pd_n), .q(pd_s));

  pwc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ring_sync (
    .clk(clk), .rst_n(rst_n), .d(ring_in), .q(ring_s));

  pwc_sync #(.WIDTH(GPIO_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_gpio_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(gpio_s));

  pwc_power_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_n_s(pd_s), .keep_ring(keep_ring), .state_q(state_q));

  pwc_wake_detect #(.GPIO_W(GPIO_W)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_s     (ring_s),
    .gpio_s     (gpio_s),
    .ring_mask  (ring_mask),
    .gpio_dir_in(gpio_dir_in),
    .gpio_mask  (gpio_mask),
    .armed      (state_q == PS_LISTEN),
    .in_run     (state_q == PS_RUN),
    .status_rd  (status_rd),
    .cause_ring (cause_ring),
    .cause_gpio (cause_gpio),
    .awake      (awake),
    .any_hit    (any_hit)
  );

  assign core_pwr_en = (state_q == PS_RUN);
  assign sif_pwr_en  = (state_q == PS_RUN) | awake;
  assign wake_irq    = cause_ring | (|cause_gpio);
  assign ring_out    = ring_s & (state_q != PS_OFF);
endmodule

// File: rtl/pwc_wake_ctrl_chk.sv
module pwc_wake_ctrl_chk
  import pwc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       core_pwr_en,
  input logic       sif_pwr_en,
  input logic       wake_irq,
  input logic       ring_out,
  input logic       status_rd,
  input pwr_state_t state_q,
  input logic       pd_s,
  input logic       any_hit
);
  assert_core_needs_sif_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_pwr_en |-> sif_pwr_en);

  assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_OFF) |-> (!sif_pwr_en && !ring_out && !core_pwr_en));

  assert_irq_rise_powers_sif_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> sif_pwr_en);

  assert_read_clears_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !any_hit) |=> !wake_irq);

  assert_read_drops_sif_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !any_hit && state_q == PS_LISTEN && !pd_s) |=> !sif_pwr_en);

  assert_read_keeps_new_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && any_hit) |=> (wake_irq && sif_pwr_en));

  assert_off_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_OFF && !pd_s) |=> (state_q == PS_OFF));

  assert_listen_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_LISTEN && !pd_s) |=> (state_q == PS_LISTEN));

  assert_release_runs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pd_s |=> core_pwr_en);
endmodule

bind pwc_wake_ctrl pwc_wake_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_pwr_en(core_pwr_en),
  .sif_pwr_en (sif_pwr_en),
  .wake_irq   (wake_irq),
  .ring_out   (ring_out),
  .status_rd  (status_rd),
  .state_q    (state_q),
  .pd_s       (pd_s),
  .any_hit    (any_hit)
);

// File: tb/test_pwc_wake_ctrl.sv
module test_pwc_wake_ctrl;
  localparam int G = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pd_n, keep_ring, ring_in, ring_mask, status_rd;
  logic [G-1:0] gpio_in, gpio_dir_in, gpio_mask;
  logic         core_pwr_en, sif_pwr_en, wake_irq, ring_out, cause_ring;
  logic [G-1:0] cause_gpio;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    started = 1'b0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  pwc_wake_ctrl #(.GPIO_W(G)) i_pwc_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .keep_ring(keep_ring),
    .ring_in(ring_in), .ring_mask(ring_mask), .gpio_in(gpio_in),
    .gpio_dir_in(gpio_dir_in), .gpio_mask(gpio_mask), .status_rd(status_rd),
    .core_pwr_en(core_pwr_en), .sif_pwr_en(sif_pwr_en), .wake_irq(wake_irq),
    .ring_out(ring_out), .cause_ring(cause_ring), .cause_gpio(cause_gpio));

  // Behavioural reference model: state 0 run, 1 full shutdown, 2 listening sleep
  bit         m_pd1, m_pd2, m_r1, m_r2, m_r3, m_cr, m_aw;
  bit [G-1:0] m_g1, m_g2, m_g3, m_cg;
  int         m_st;

  always @(posedge clk or negedge rst_n) begin : model
    int         nst;
    bit         rh;
    bit [G-1:0] gh;
    bit         hit;
    if (!rst_n) begin
      m_pd1 = 1; m_pd2 = 1; m_r1 = 0; m_r2 = 0; m_r3 = 0;
      m_g1 = 0; m_g2 = 0; m_g3 = 0; m_st = 0; m_cr = 0; m_cg = 0; m_aw = 0;
    end else begin
      rh  = (m_st == 2) && m_r2 && !m_r3 && !ring_mask;
      gh  = (m_st == 2) ? (m_g2 & ~m_g3 & gpio_dir_in & ~gpio_mask) : '0;
      hit = rh || (gh != 0);
      if (m_pd2)          nst = 0;
      else if (m_st == 0) nst = keep_ring ? 2 : 1;
      else                nst = m_st;
      if (m_st == 0) m_aw = 0;
      else           m_aw = (status_rd ? 1'b0 : m_aw) | hit;
      m_cr = (status_rd ? 1'b0 : m_cr) | rh;
      m_cg = (status_rd ? '0 : m_cg) | gh;
      m_st = nst;
      m_r3 = m_r2; m_r2 = m_r1; m_r1 = ring_in;
      m_g3 = m_g2; m_g2 = m_g1; m_g1 = gpio_in;
      m_pd2 = m_pd1; m_pd1 = pd_n;
    end
  end

  task automatic expect_val(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare every output against the model on each clock
  always @(negedge clk) begin
    if (started && rst_n) begin
      expect_val(phase, "core_pwr_en", 32'(core_pwr_en), 32'(m_st == 0));
      expect_val(phase, "sif_pwr_en",  32'(sif_pwr_en),  32'((m_st == 0) || m_aw));
      expect_val(phase, "wake_irq",    32'(wake_irq),    32'(m_cr || (m_cg != 0)));
      expect_val(phase, "ring_out",    32'(ring_out),    32'(m_r2 && (m_st != 1)));
      expect_val(phase, "cause_ring",  32'(cause_ring),  32'(m_cr));
      expect_val(phase, "cause_gpio",  32'(cause_gpio),  32'(m_cg));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    status_rd = 1'b1; tick(1); status_rd = 1'b0;
  endtask

  initial begin : stim
    rst_n = 1'b0; pd_n = 1'b1; keep_ring = 1'b0; ring_in = 1'b0; ring_mask = 1'b0;
    status_rd = 1'b0; gpio_in = '0; gpio_dir_in = '1; gpio_mask = '0;
    tick(3);
    rst_n = 1'b1; started = 1'b1;
    tick(2);
    phase = "R1";
    expect_val("R1", "core after reset", 32'(core_pwr_en), 1);
    expect_val("R1", "sif after reset",  32'(sif_pwr_en),  1);
    expect_val("R1", "irq after reset",  32'(wake_irq),    0);

    // R2 latency and R3 full shutdown
    phase = "R2";
    pd_n = 1'b0;
    tick(2);
    expect_val("R2", "core still on before latency", 32'(core_pwr_en), 1);
    tick(1);
    expect_val("R2", "core off after three edges", 32'(core_pwr_en), 0);
    phase = "R3";
    ring_in = 1'b1; tick(5);
    expect_val("R3", "irq ignores ring in shutdown", 32'(wake_irq), 0);
    expect_val("R3", "ring_out blocked",             32'(ring_out), 0);
    ring_in = 1'b0; gpio_in[0] = 1'b1; tick(5);
    expect_val("R3", "irq ignores gpio in shutdown", 32'(wake_irq),   0);
    expect_val("R3", "sif stays off",                32'(sif_pwr_en), 0);
    gpio_in[0] = 1'b0; tick(3);

    // R9 mode change while asleep has no effect
    phase = "R9";
    keep_ring = 1'b1; tick(2);
    ring_in = 1'b1; tick(5);
    expect_val("R9", "still shut down after mode change", 32'(wake_irq), 0);
    expect_val("R9", "ring_out still blocked",            32'(ring_out), 0);
    ring_in = 1'b0; tick(3);

    // R10 release
    phase = "R10";
    pd_n = 1'b1; tick(3);
    expect_val("R10", "core on after release", 32'(core_pwr_en), 1);
    expect_val("R10", "sif on after release",  32'(sif_pwr_en),  1);

    // R4 listening sleep with all sources masked
    phase = "R4";
    ring_mask = 1'b1; gpio_mask = '1;
    pd_n = 1'b0; tick(4);
    ring_in = 1'b1; tick(4);
    expect_val("R4", "ring_out follows ring",   32'(ring_out),   1);
    expect_val("R4", "masked ring no irq",      32'(wake_irq),   0);
    expect_val("R4", "masked ring sif off",     32'(sif_pwr_en), 0);
    ring_in = 1'b0; gpio_in[2] = 1'b1; tick(4);
    expect_val("R4", "masked gpio no irq",      32'(wake_irq),   0);
    gpio_in[2] = 1'b0; tick(3);

    // R6 gpio qualification
    phase = "R6";
    gpio_mask[1] = 1'b0; gpio_dir_in[1] = 1'b0;
    gpio_in[1] = 1'b1; tick(4);
    expect_val("R6", "output-configured gpio no irq", 32'(wake_irq), 0);
    gpio_in[1] = 1'b0; gpio_dir_in[1] = 1'b1; tick(4);
    expect_val("R6", "falling edge no irq", 32'(wake_irq), 0);
    gpio_in[1] = 1'b1; tick(3);
    expect_val("R6", "gpio wake irq",   32'(wake_irq),   1);
    expect_val("R6", "gpio cause bit",  32'(cause_gpio), 32'h2);
    expect_val("R6", "gpio wake sif",   32'(sif_pwr_en), 1);
    tick(2);

    // R7 read clears and turns interface off
    phase = "R7";
    pulse_rd();
    expect_val("R7", "irq cleared",    32'(wake_irq),   0);
    expect_val("R7", "cause cleared",  32'(cause_gpio), 0);
    expect_val("R7", "sif off again",  32'(sif_pwr_en), 0);
    gpio_in[1] = 1'b0; tick(3);

    // R5 ring wake
    phase = "R5";
    ring_mask = 1'b0;
    ring_in = 1'b1; tick(3);
    expect_val("R5", "ring wake irq",   32'(wake_irq),   1);
    expect_val("R5", "ring cause bit",  32'(cause_ring), 1);
    expect_val("R5", "ring wake sif",   32'(sif_pwr_en), 1);
    ring_in = 1'b0; tick(2);

    // R8 read colliding with a new gpio event
    phase = "R8";
    gpio_in[1] = 1'b1; tick(2);
    pulse_rd();
    expect_val("R8", "ring cause cleared",  32'(cause_ring), 0);
    expect_val("R8", "gpio cause kept",     32'(cause_gpio), 32'h2);
    expect_val("R8", "irq reasserted",      32'(wake_irq),   1);
    expect_val("R8", "sif kept powered",    32'(sif_pwr_en), 1);
    tick(2);

    // R10 return to run keeps unread causes
    phase = "R10";
    pd_n = 1'b1; tick(3);
    expect_val("R10", "core on",          32'(core_pwr_en), 1);
    expect_val("R10", "unread cause kept", 32'(cause_gpio), 32'h2);
    pulse_rd();
    expect_val("R10", "read in run clears", 32'(wake_irq), 0);
    tick(3);
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule